// File: doc/BRIEF.md
# Register-Window Trap Entry Sequencer

This block carries out the state changes a register-windowed processor makes when it takes a trap. A request arrives with an 8-bit trap type, the program counter and next program counter, the current window pointer, the supervisor bit and the trap-enable bit. The block registers these values in the cycle the request is accepted.

If traps are enabled, the next cycle moves to the window below the current one, wrapping around at zero. The same cycle drives two register-file write ports that store the program counter and next program counter into that new window. It also presents the updated mode bits and pulses `done`.

If traps are disabled, no window or register update takes place. The block enters a terminal error state. The one exception is trap type 0x80 when the shutdown feature input is high: that case raises a clean shutdown request instead. Both outcomes hold until reset.

Four states are used:
- `ST_IDLE` waits for a request.
- `ST_ENTER` is the one-cycle trap entry.
- `ST_ERROR` is the halting error.
- `ST_SHUTDOWN` is the clean stop.

Transitions:
- IDLE→ENTER: a request with traps enabled.
- IDLE→ERROR: a request with traps disabled that does not qualify for shutdown.
- IDLE→SHUTDOWN: a request with traps disabled, type 0x80 and the feature input high.
- ENTER→IDLE: always, one cycle later.
- ERROR and SHUTDOWN: never left before reset.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the block is idle: `done`, `wr_en`, `error_halt` and `shutdown_req` are 0.
- R2: A request with `et_in`=1, sampled at clock edge k, gives `done`=1 and `wr_en`=1 for exactly the cycle after edge k.
- R3: On entry, `cwp_out` and `wr_win` both equal the old window pointer minus one, with 0 wrapping to NWIN-1.
- R4: On entry, `wr_pc` carries the sampled PC with `wr_idx_pc`=17 (local 1), and `wr_npc` carries the sampled next PC with `wr_idx_npc`=18 (local 2).
- R5: On entry, `ps_out` equals the sampled `s_in`, `s_out`=1 and `et_out`=0.
- R6: A request with `et_in`=0 makes no update (`done`=0, `wr_en`=0) and sets `error_halt` after that edge, unless R7 applies.
- R7: A request with `et_in`=0, `trap_type`=0x80 and `shutdown_feat`=1 sets `shutdown_req` and leaves `error_halt` at 0.
- R8: Type 0x80 without `shutdown_feat`, or any other type with `shutdown_feat`, leads to `error_halt` when traps are disabled. With traps enabled, type 0x80 is an ordinary entry.
- R9: `error_halt` and `shutdown_req` stay set until reset, and later requests produce no `done` or write.
- R10: During `done`, `is_sw_trap` is 1 exactly when the sampled type is 0x80 or higher.
- R11: A request present in the `ST_ENTER` cycle is ignored. A request held high for three edges therefore gives `done` in the cycles after the first and third edges only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request |
| trap_type | input | 8 | Trap type |
| shutdown_feat | input | 1 | Enables clean shutdown for type 0x80 |
| pc_in | input | XLEN | Current PC |
| npc_in | input | XLEN | Next PC |
| cwp_in | input | CWP_W | Current window pointer |
| s_in | input | 1 | Current supervisor bit |
| et_in | input | 1 | Trap-enable bit |
| done | output | 1 | Trap entry completed (one cycle) |
| is_sw_trap | output | 1 | Entered trap is a software trap |
| cwp_out | output | CWP_W | New window pointer |
| et_out | output | 1 | New trap-enable bit |
| s_out | output | 1 | New supervisor bit |
| ps_out | output | 1 | New previous-supervisor bit |
| wr_en | output | 1 | Register-file write enable |
| wr_win | output | CWP_W | Window addressed by the writes |
| wr_idx_pc | output | 5 | Register index for the PC write |
| wr_pc | output | XLEN | PC write data |
| wr_idx_npc | output | 5 | Register index for the next-PC write |
| wr_npc | output | XLEN | Next-PC write data |
| error_halt | output | 1 | Sticky error state |
| shutdown_req | output | 1 | Sticky clean shutdown request |

## Verification
The hardest situations to reach are the terminal states, because they are sticky and each one needs a fresh reset. The bench therefore resets between every disabled-trap case: plain error, qualified shutdown, type 0x80 without the feature, and a qualifying feature with another type. After each terminal state it issues an enabled request to show that nothing moves. The request that lands in the entry cycle is reached by holding `trap_req` high across three edges.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENTER,
        ST_ERROR,
        ST_SHUTDOWN
    } seq_state_e;

    localparam logic [4:0] LOC1_IDX    = 5'd17;
    localparam logic [4:0] LOC2_IDX    = 5'd18;
    localparam logic [7:0] TT_SHUTDOWN = 8'h80;
    localparam logic [7:0] TT_SW_MIN   = 8'h80;
endpackage

// File: rtl/trap_cls.sv
module trap_cls
    import trap_entry_pkg::*;
#(
    parameter int TT_W = 8
) (
    input  logic [TT_W-1:0] tt,
    input  logic            feat,
    output logic            is_sw,
    output logic            sd_hit
);
    always_comb begin
        is_sw  = (tt >= TT_W'(TT_SW_MIN));
        sd_hit = feat && (tt == TT_W'(TT_SHUTDOWN));
    end
endmodule

// File: rtl/win_dec.sv
module win_dec #(
    parameter int NWIN  = 8,
    parameter int CWP_W = 3
) (
    input  logic [CWP_W-1:0] cur,
    output logic [CWP_W-1:0] nxt
);
    localparam bit POW2 = ((1 << CWP_W) == NWIN);

    generate
        if (POW2) begin : g_pow2
            assign nxt = cur - CWP_W'(1);
        end else begin : g_mod
            assign nxt = (cur == '0) ? CWP_W'(NWIN - 1) : cur - CWP_W'(1);
        end
    endgenerate
endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
    import trap_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       et,
    input  logic       sd_hit,
    output seq_state_e state
);
    seq_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (et)          nxt = ST_ENTER;
                    else if (sd_hit) nxt = ST_SHUTDOWN;
                    else             nxt = ST_ERROR;
                end
            end
            ST_ENTER:    nxt = ST_IDLE;
            ST_ERROR:    nxt = ST_ERROR;
            ST_SHUTDOWN: nxt = ST_SHUTDOWN;
            default:     nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_entry_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int XLEN  = 32,
    parameter int TT_W  = 8,
    parameter int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [TT_W-1:0]  trap_type,
    input  logic             shutdown_feat,
    input  logic [XLEN-1:0]  pc_in,
    input  logic [XLEN-1:0]  npc_in,
    input  logic [CWP_W-1:0] cwp_in,
    input  logic             s_in,
    input  logic             et_in,
    output logic             done,
    output logic             is_sw_trap,
    output logic [CWP_W-1:0] cwp_out,
    output logic             et_out,
    output logic             s_out,
    output logic             ps_out,
    output logic             wr_en,
    output logic [CWP_W-1:0] wr_win,
    output logic [4:0]       wr_idx_pc,
    output logic [XLEN-1:0]  wr_pc,
    output logic [4:0]       wr_idx_npc,
    output logic [XLEN-1:0]  wr_npc,
    output logic             error_halt,
    output logic             shutdown_req
);
    seq_state_e       state;
    logic             is_sw_c, sd_hit_c;
    logic [CWP_W-1:0] cwp_dec_c;

    logic [XLEN-1:0]  pc_q, npc_q;
    logic [CWP_W-1:0] win_q;
    logic             s_q, sw_q;

    trap_cls #(.TT_W(TT_W)) cls_i (
        .tt     (trap_type),
        .feat   (shutdown_feat),
        .is_sw  (is_sw_c),
        .sd_hit (sd_hit_c)
    );

    win_dec #(.NWIN(NWIN), .CWP_W(CWP_W)) wdec_i (
        .cur (cwp_in),
        .nxt (cwp_dec_c)
    );

    trap_seq_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (trap_req),
        .et     (et_in),
        .sd_hit (sd_hit_c),
        .state  (state)
    );

    // Capture operands when a request is accepted in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            npc_q <= '0;
            win_q <= '0;
            s_q   <= 1'b0;
            sw_q  <= 1'b0;
        end else if (state == ST_IDLE && trap_req) begin
            pc_q  <= pc_in;
            npc_q <= npc_in;
            win_q <= cwp_dec_c;
            s_q   <= s_in;
            sw_q  <= is_sw_c;
        end
    end

    // Output process, driven from state.
    always_comb begin
        done         = 1'b0;
        is_sw_trap   = 1'b0;
        cwp_out      = '0;
        et_out       = 1'b0;
        s_out        = 1'b0;
        ps_out       = 1'b0;
        wr_en        = 1'b0;
        wr_win       = '0;
        wr_idx_pc    = '0;
        wr_pc        = '0;
        wr_idx_npc   = '0;
        wr_npc       = '0;
        error_halt   = 1'b0;
        shutdown_req = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ENTER: begin
                done       = 1'b1;
                is_sw_trap = sw_q;
                cwp_out    = win_q;
                et_out     = 1'b0;
                s_out      = 1'b1;
                ps_out     = s_q;
                wr_en      = 1'b1;
                wr_win     = win_q;
                wr_idx_pc  = LOC1_IDX;
                wr_pc      = pc_q;
                wr_idx_npc = LOC2_IDX;
                wr_npc     = npc_q;
            end
            ST_ERROR:    error_halt   = 1'b1;
            ST_SHUTDOWN: shutdown_req = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int NWIN  = 8,
    parameter int XLEN  = 32,
    parameter int TT_W  = 8,
    parameter int CWP_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trap_req,
    input logic [TT_W-1:0]  trap_type,
    input logic             shutdown_feat,
    input logic [XLEN-1:0]  pc_in,
    input logic [XLEN-1:0]  npc_in,
    input logic [CWP_W-1:0] cwp_in,
    input logic             s_in,
    input logic             et_in,
    input logic             done,
    input logic             is_sw_trap,
    input logic [CWP_W-1:0] cwp_out,
    input logic             et_out,
    input logic             s_out,
    input logic             ps_out,
    input logic             wr_en,
    input logic [CWP_W-1:0] wr_win,
    input logic [XLEN-1:0]  wr_pc,
    input logic [XLEN-1:0]  wr_npc,
    input logic             error_halt,
    input logic             shutdown_req
);
    logic idle_like;
    assign idle_like = !done && !error_halt && !shutdown_req;

    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_like && trap_req && et_in |=> done && wr_en);

    assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_win == cwp_out) &&
                 (cwp_out == (($past(cwp_in) == '0) ? CWP_W'(NWIN - 1)
                                                    : $past(cwp_in) - CWP_W'(1))));

    assert_saved_pcs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_pc == $past(pc_in)) && (wr_npc == $past(npc_in)));

    assert_mode_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ps_out == $past(s_in)) && s_out && !et_out);

    assert_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_like && trap_req && !et_in |=> !done && !wr_en && (error_halt || shutdown_req));

    assert_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idle_like && trap_req && !et_in && shutdown_feat && (trap_type == TT_W'(8'h80))
        |=> shutdown_req && !error_halt);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error_halt |=> error_halt && !wr_en);

    assert_sd_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req && !wr_en);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(error_halt && shutdown_req));

    assert_sw_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (is_sw_trap == ($past(trap_type) >= TT_W'(8'h80))));
endmodule

bind trap_entry_seq trap_entry_chk #(
    .NWIN(NWIN), .XLEN(XLEN), .TT_W(TT_W), .CWP_W(CWP_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .shutdown_feat(shutdown_feat), .pc_in(pc_in), .npc_in(npc_in),
    .cwp_in(cwp_in), .s_in(s_in), .et_in(et_in), .done(done),
    .is_sw_trap(is_sw_trap), .cwp_out(cwp_out), .et_out(et_out),
    .s_out(s_out), .ps_out(ps_out), .wr_en(wr_en), .wr_win(wr_win),
    .wr_pc(wr_pc), .wr_npc(wr_npc), .error_halt(error_halt),
    .shutdown_req(shutdown_req)
);

// File: tb/trap_entry_seq_tb_top.sv
`timescale 1ns/1ps
module trap_entry_seq_tb_top;
    localparam int NWIN  = 8;
    localparam int XLEN  = 32;
    localparam int CWP_W = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             trap_req;
    logic [7:0]       trap_type;
    logic             shutdown_feat;
    logic [XLEN-1:0]  pc_in, npc_in;
    logic [CWP_W-1:0] cwp_in;
    logic             s_in, et_in;
    logic             done, is_sw_trap, et_out, s_out, ps_out, wr_en;
    logic [CWP_W-1:0] cwp_out, wr_win;
    logic [4:0]       wr_idx_pc, wr_idx_npc;
    logic [XLEN-1:0]  wr_pc, wr_npc;
    logic             error_halt, shutdown_req;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    trap_entry_seq #(.NWIN(NWIN), .XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .shutdown_feat(shutdown_feat), .pc_in(pc_in), .npc_in(npc_in),
        .cwp_in(cwp_in), .s_in(s_in), .et_in(et_in), .done(done),
        .is_sw_trap(is_sw_trap), .cwp_out(cwp_out), .et_out(et_out),
        .s_out(s_out), .ps_out(ps_out), .wr_en(wr_en), .wr_win(wr_win),
        .wr_idx_pc(wr_idx_pc), .wr_pc(wr_pc), .wr_idx_npc(wr_idx_npc),
        .wr_npc(wr_npc), .error_halt(error_halt), .shutdown_req(shutdown_req)
    );

    // vector: {type[7:0], cwp[2:0], s, pc[31:0]}
    localparam int NV = 6;
    localparam logic [43:0] VEC [NV] = '{
        {8'h05, 3'd3, 1'b0, 32'h0000_1000},
        {8'h80, 3'd0, 1'b1, 32'h4000_0040},
        {8'h2A, 3'd7, 1'b1, 32'hFFFF_FFF8},
        {8'h7F, 3'd1, 1'b0, 32'h1234_5670},
        {8'hFF, 3'd0, 1'b0, 32'h0000_0004},
        {8'h90, 3'd5, 1'b1, 32'hA5A5_A5A0}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; trap_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive a one-cycle request at a negedge; return at the following negedge.
    task automatic pulse_req(input logic [7:0] tt, input logic [CWP_W-1:0] cw,
                             input logic s, input logic et, input logic feat,
                             input logic [XLEN-1:0] pc);
        trap_type = tt; cwp_in = cw; s_in = s; et_in = et;
        shutdown_feat = feat; pc_in = pc; npc_in = pc + 32'd4;
        trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; trap_req = 1'b0; trap_type = '0; shutdown_feat = 1'b0;
        pc_in = '0; npc_in = '0; cwp_in = '0; s_in = 1'b0; et_in = 1'b0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "wr_en", 64'(wr_en), 64'd0);
        chk("R1", "error_halt", 64'(error_halt), 64'd0);
        chk("R1", "shutdown_req", 64'(shutdown_req), 64'd0);

        // Table-driven enabled trap entries (feature high: R8 normal 0x80 entry)
        for (int i = 0; i < NV; i++) begin
            logic [7:0]       tt;
            logic [CWP_W-1:0] cw, ecw;
            logic             s;
            logic [XLEN-1:0]  pc;
            {tt, cw, s, pc} = VEC[i];
            ecw = (cw == 0) ? CWP_W'(NWIN - 1) : cw - 1'b1;
            pulse_req(tt, cw, s, 1'b1, 1'b1, pc);
            chk("R2", "done", 64'(done), 64'd1);
            chk("R2", "wr_en", 64'(wr_en), 64'd1);
            chk("R3", "cwp_out", 64'(cwp_out), 64'(ecw));
            chk("R3", "wr_win", 64'(wr_win), 64'(ecw));
            chk("R4", "wr_idx_pc", 64'(wr_idx_pc), 64'd17);
            chk("R4", "wr_pc", 64'(wr_pc), 64'(pc));
            chk("R4", "wr_idx_npc", 64'(wr_idx_npc), 64'd18);
            chk("R4", "wr_npc", 64'(wr_npc), 64'(pc + 32'd4));
            chk("R5", "ps_out", 64'(ps_out), 64'(s));
            chk("R5", "s_out", 64'(s_out), 64'd1);
            chk("R5", "et_out", 64'(et_out), 64'd0);
            chk("R10", "is_sw_trap", 64'(is_sw_trap), 64'(tt >= 8'h80));
            chk("R8", "no error on enabled 0x80", 64'(error_halt | shutdown_req), 64'd0);
            @(negedge clk);
            chk("R2", "done one cycle", 64'(done), 64'd0);
        end

        // R11: request held across three edges
        trap_type = 8'h11; cwp_in = 3'd4; s_in = 1'b1; et_in = 1'b1;
        shutdown_feat = 1'b0; pc_in = 32'h100; npc_in = 32'h104;
        trap_req = 1'b1;
        @(negedge clk);
        chk("R11", "first done", 64'(done), 64'd1);
        @(negedge clk);
        chk("R11", "ignored during entry", 64'(done), 64'd0);
        @(negedge clk);
        chk("R11", "third edge accepted", 64'(done), 64'd1);
        trap_req = 1'b0;
        @(negedge clk);
        chk("R11", "released", 64'(done), 64'd0);

        // R6 + R9: disabled plain trap
        do_reset();
        pulse_req(8'h05, 3'd2, 1'b1, 1'b0, 1'b0, 32'h200);
        chk("R6", "done", 64'(done), 64'd0);
        chk("R6", "wr_en", 64'(wr_en), 64'd0);
        chk("R6", "error_halt", 64'(error_halt), 64'd1);
        chk("R6", "shutdown_req", 64'(shutdown_req), 64'd0);
        pulse_req(8'h05, 3'd2, 1'b1, 1'b1, 1'b0, 32'h200);
        chk("R9", "no done in error", 64'(done), 64'd0);
        chk("R9", "no write in error", 64'(wr_en), 64'd0);
        @(negedge clk);
        chk("R9", "error sticky", 64'(error_halt), 64'd1);

        // R7 + R9: qualified shutdown
        do_reset();
        pulse_req(8'h80, 3'd6, 1'b0, 1'b0, 1'b1, 32'h300);
        chk("R7", "shutdown_req", 64'(shutdown_req), 64'd1);
        chk("R7", "error_halt", 64'(error_halt), 64'd0);
        chk("R7", "wr_en", 64'(wr_en), 64'd0);
        pulse_req(8'h01, 3'd6, 1'b0, 1'b1, 1'b1, 32'h300);
        chk("R9", "no done in shutdown", 64'(done), 64'd0);
        chk("R9", "shutdown sticky", 64'(shutdown_req), 64'd1);

        // R8: 0x80 without feature
        do_reset();
        pulse_req(8'h80, 3'd1, 1'b0, 1'b0, 1'b0, 32'h400);
        chk("R8", "0x80 no feat error", 64'(error_halt), 64'd1);
        chk("R8", "0x80 no feat shutdown", 64'(shutdown_req), 64'd0);

        // R8: other type with feature
        do_reset();
        pulse_req(8'h81, 3'd1, 1'b0, 1'b0, 1'b1, 32'h500);
        chk("R8", "0x81 feat error", 64'(error_halt), 64'd1);
        chk("R8", "0x81 feat shutdown", 64'(shutdown_req), 64'd0);

        // R1: reset clears a terminal state
        do_reset();
        @(negedge clk);
        chk("R1", "error cleared", 64'(error_halt), 64'd0);

        finish_run();
    end
endmodule